// File: doc/BRIEF.md
# Narrow-Access 32-bit Register Cache Bridge

This block lets a host bus that moves only 8 or 16 bits per transfer reach registers that can only be read or written as whole 32-bit words. Each register spans four byte addresses in big-endian order: the most significant byte sits at the lowest address and the least significant byte at the highest. The host presents a byte address, a size bit (byte or halfword) and write data. The bridge turns these into whole-word strobes on a 32-bit register port.

Two shared caches keep accesses coherent. A read that covers the top byte fetches the full word once and keeps it. Later reads of the lower bytes are served from that copy, so the word cannot change between the pieces. Writes that miss the bottom byte are parked in a write cache. The transfer that covers the bottom byte sends one whole-word write, built from the parked bytes and the bytes now on the bus. Software must therefore read top-first and write bottom-last. There is one cache of each kind, not one per register, so a stale cache can mix data from different registers.

The register port is combinational: the strobes, address and write word are valid in the same cycle as the host request. Read data comes back on the host port one cycle later.

Top module: `narrow_reg_bridge`

## Requirements
- R1: After reset `h_rvalid` and `h_rdata` are zero. Both caches hold zero: a lone byte read at offset 3 returns 0x00, and a lone byte write at offset 3 of value V writes 0x000000V.
- R2: Byte lane k (k = address bits [1:0]) is register bits [31-8k : 24-8k], so lane 0 is the most significant byte. A byte access touches lane k. A halfword access touches lanes 2b and 2b+1, where b = address bit 1, and it ignores address bit 0. Halfword data has the lower-address lane in bus bits [15:8].
- R3: A read that touches lane 0 raises `r_rd` in the request cycle with `r_addr` = `h_addr[ADDR_W-1:2]`. The full `r_rdata` is kept in the read cache.
- R4: A read that does not touch lane 0 leaves `r_rd` low. It returns bytes from the read cache, even when the cache was filled from a different register.
- R5: One cycle after a read request, `h_rvalid` is 1. `h_rdata` then holds the selected lanes: a halfword fills all 16 bits, and a byte fills bits [7:0] with zeros above.
- R6: A write that does not touch lane 3 leaves `r_wr` low. It stores its bytes in the matching lanes of the write cache.
- R7: A write that touches lane 3 raises `r_wr` in the request cycle with `r_addr` = `h_addr[ADDR_W-1:2]`. Every lane the write touches takes its byte from the bus, and every other lane takes its byte from the write cache.
- R8: A committing write does not change the write cache. The cached bytes are reused by any later commit, to any register.
- R9: Reads do not change the write cache, and writes do not change the read cache.
- R10: With `h_req` low, `r_rd` and `r_wr` stay low, and `h_rvalid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host transfer request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Host byte address |
| h_size | input | 1 | 0 = byte, 1 = halfword |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_rvalid | output | 1 | Read data valid, one cycle after a read request |
| r_addr | output | ADDR_W-2 | Register word address |
| r_rd | output | 1 | Whole-word register read strobe |
| r_wr | output | 1 | Whole-word register write strobe |
| r_wdata | output | 32 | Whole-word register write data |
| r_rdata | input | 32 | Register read data, valid in the same cycle as `r_rd` |

## Verification
Two things can happen in the same cycle. A refill read loads the read cache and returns bytes of the same word on the same edge. A commit write can also be issued while the response to the read just before it is still on the host port. The bench sends requests back to back with no idle cycles: refill then partial reads, refill reads of different registers in a row, and commits straight after reads. A behavioural byte model, fed only from the host stimulus, predicts the strobes, address and write word in each request cycle and the read data in the next cycle, and these are compared every cycle.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int BYTE_W    = 8;
    localparam int REG_BYTES = 4;
    localparam int REG_W     = BYTE_W * REG_BYTES;
    localparam int BUS_W     = 2 * BYTE_W;
    localparam int LANE_W    = $clog2(REG_BYTES);

    // Bridge state: both caches plus the registered host read response
    typedef struct packed {
        logic [REG_W-1:0] rcache;
        logic [REG_W-1:0] wcache;
        logic [BUS_W-1:0] rdata;
        logic             rvalid;
    } bridge_state_t;

    // Byte lane 0 is the most significant byte (big-endian order)
    function automatic logic [BYTE_W-1:0] lane_byte(input logic [REG_W-1:0] w,
                                                    input logic [LANE_W-1:0] lane);
        return w[REG_W-1 - BYTE_W*int'(lane) -: BYTE_W];
    endfunction
endpackage

// File: rtl/nbr_lane_decode.sv
module nbr_lane_decode
    import nbr_pkg::*;
(
    input  logic [LANE_W-1:0]    addr_lo,
    input  logic                 size,
    output logic [REG_BYTES-1:0] lanes,
    output logic [LANE_W-1:0]    first,
    output logic [LANE_W-1:0]    second
);
    // Halfword accesses are aligned: address bit 0 is ignored
    assign first  = size ? {addr_lo[LANE_W-1:1], 1'b0} : addr_lo;
    assign second = first + LANE_W'(1);

    for (genvar i = 0; i < REG_BYTES; i++) begin : g_lane
        assign lanes[i] = (first == LANE_W'(i)) || (size && (second == LANE_W'(i)));
    end
endmodule

// File: rtl/nbr_wr_merge.sv
module nbr_wr_merge
    import nbr_pkg::*;
(
    input  logic [REG_W-1:0]     cache,
    input  logic [REG_BYTES-1:0] lanes,
    input  logic [LANE_W-1:0]    first,
    input  logic                 size,
    input  logic [BUS_W-1:0]     bus,
    output logic [REG_W-1:0]     merged
);
    for (genvar i = 0; i < REG_BYTES; i++) begin : g_lane
        logic [BYTE_W-1:0] byte_in;
        // Lower-address lane of a halfword rides in the upper bus byte
        assign byte_in = (size && (first == LANE_W'(i))) ? bus[BUS_W-1 -: BYTE_W]
                                                         : bus[BYTE_W-1:0];
        assign merged[REG_W-1 - BYTE_W*i -: BYTE_W] =
            lanes[i] ? byte_in : cache[REG_W-1 - BYTE_W*i -: BYTE_W];
    end
endmodule

// File: rtl/nbr_rd_steer.sv
module nbr_rd_steer
    import nbr_pkg::*;
(
    input  logic [REG_W-1:0]  word,
    input  logic [LANE_W-1:0] first,
    input  logic [LANE_W-1:0] second,
    input  logic              size,
    output logic [BUS_W-1:0]  data
);
    always_comb begin
        if (size) begin
            data = {lane_byte(word, first), lane_byte(word, second)};
        end else begin
            data = {{BYTE_W{1'b0}}, lane_byte(word, first)};
        end
    end
endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    h_req,
    input  logic                    h_wr,
    input  logic [ADDR_W-1:0]       h_addr,
    input  logic                    h_size,
    input  logic [BUS_W-1:0]        h_wdata,
    output logic [BUS_W-1:0]        h_rdata,
    output logic                    h_rvalid,
    output logic [ADDR_W-LANE_W-1:0] r_addr,
    output logic                    r_rd,
    output logic                    r_wr,
    output logic [REG_W-1:0]        r_wdata,
    input  logic [REG_W-1:0]        r_rdata
);
    localparam int MSB_LANE = 0;
    localparam int LSB_LANE = REG_BYTES - 1;

    bridge_state_t st_d, st_q;

    logic [REG_BYTES-1:0] lanes;
    logic [LANE_W-1:0]    first, second;
    logic [REG_W-1:0]     merged;
    logic [REG_W-1:0]     src_word;
    logic [BUS_W-1:0]     steer_out;
    logic                 has_msb, has_lsb, rd_go, wr_go;

    nbr_lane_decode u_dec (
        .addr_lo (h_addr[LANE_W-1:0]),
        .size    (h_size),
        .lanes   (lanes),
        .first   (first),
        .second  (second)
    );

    nbr_wr_merge u_merge (
        .cache   (st_q.wcache),
        .lanes   (lanes),
        .first   (first),
        .size    (h_size),
        .bus     (h_wdata),
        .merged  (merged)
    );

    nbr_rd_steer u_steer (
        .word    (src_word),
        .first   (first),
        .second  (second),
        .size    (h_size),
        .data    (steer_out)
    );

    assign has_msb  = lanes[MSB_LANE];
    assign has_lsb  = lanes[LSB_LANE];
    assign rd_go    = h_req && !h_wr;
    assign wr_go    = h_req && h_wr;

    // Register port: combinational, valid in the request cycle
    assign r_rd     = rd_go && has_msb;
    assign r_wr     = wr_go && has_lsb;
    assign r_addr   = h_addr[ADDR_W-1:LANE_W];
    assign r_wdata  = merged;

    // A refill read answers from the live word, any other read from the cache
    assign src_word = has_msb ? r_rdata : st_q.rcache;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_go;
        if (rd_go) begin
            st_d.rdata = steer_out;
            if (has_msb) begin
                st_d.rcache = r_rdata;
            end
        end
        if (wr_go && !has_lsb) begin
            st_d.wcache = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_rdata  = st_q.rdata;
    assign h_rvalid = st_q.rvalid;
endmodule

// File: rtl/narrow_reg_bridge_chk.sv
module narrow_reg_bridge_chk
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     h_req,
    input logic                     h_wr,
    input logic [ADDR_W-1:0]        h_addr,
    input logic                     h_size,
    input logic [BUS_W-1:0]         h_wdata,
    input logic [BUS_W-1:0]         h_rdata,
    input logic                     h_rvalid,
    input logic [ADDR_W-LANE_W-1:0] r_addr,
    input logic                     r_rd,
    input logic                     r_wr,
    input logic [REG_W-1:0]         r_wdata,
    input logic [REG_W-1:0]         r_rdata
);
    logic              top_in, bot_in;
    logic [BYTE_W-1:0] live_top;

    assign top_in   = h_size ? !h_addr[1] : (h_addr[1:0] == 2'b00);
    assign bot_in   = h_size ?  h_addr[1] : (h_addr[1:0] == 2'b11);
    assign live_top = r_rdata[REG_W-1 -: BYTE_W];

    AST_RD_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |-> (h_req && !h_wr && top_in)); // R3
    AST_TOP_READ_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_wr && top_in) |-> (r_rd && r_addr == h_addr[ADDR_W-1:LANE_W])); // R3
    AST_PARTIAL_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_wr && !top_in) |-> !r_rd); // R4
    AST_WR_NEEDS_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr |-> (h_req && h_wr && bot_in)); // R7
    AST_PARTIAL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_wr && !bot_in) |-> !r_wr); // R6
    AST_HALF_COMMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && h_size) |-> (r_wdata[BUS_W-1:0] == h_wdata)); // R7
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_wr) |=> h_rvalid); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !h_req |-> (!r_rd && !r_wr)); // R10
    AST_IDLE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !h_req |=> !h_rvalid); // R10
    AST_TOP_BYTE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_wr && !h_size && h_addr[1:0] == 2'b00)
            |=> (h_rdata == {{BYTE_W{1'b0}}, $past(live_top)})); // R5
endmodule

bind narrow_reg_bridge narrow_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_req    (h_req),
    .h_wr     (h_wr),
    .h_addr   (h_addr),
    .h_size   (h_size),
    .h_wdata  (h_wdata),
    .h_rdata  (h_rdata),
    .h_rvalid (h_rvalid),
    .r_addr   (r_addr),
    .r_rd     (r_rd),
    .r_wr     (r_wr),
    .r_wdata  (r_wdata),
    .r_rdata  (r_rdata)
);

// File: tb/sim_narrow_reg_bridge.sv
module sim_narrow_reg_bridge;
    localparam int AW   = 8;
    localparam int NREG = 1 << (AW - 2);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        h_req, h_wr, h_size;
    logic [AW-1:0] h_addr;
    logic [15:0] h_wdata, h_rdata;
    logic        h_rvalid;
    logic [AW-3:0] r_addr;
    logic        r_rd, r_wr;
    logic [31:0] r_wdata, r_rdata;

    logic [31:0] mem [0:NREG-1];
    logic [7:0]  rc [0:3];
    logic [7:0]  wc [0:3];
    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    narrow_reg_bridge #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
        .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .r_addr(r_addr), .r_rd(r_rd), .r_wr(r_wr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    assign r_rdata = mem[r_addr];

    always @(posedge clk) begin
        if (r_wr) mem[r_addr] <= r_wdata;
    end

    task automatic check_eq(input string rq, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // One host cycle: predict from a byte-level model, compare every output
    task automatic op(input bit req, input bit wr, input logic [AW-1:0] addr,
                      input bit size, input logic [15:0] wd, input string rq);
        int first, n;
        bit exp_rd, exp_wr;
        logic [31:0] word, expw;
        logic [15:0] expr;
        logic [7:0] bus [0:3];
        bit on_bus [0:3];
        first  = size ? int'(addr[1]) * 2 : int'(addr[1:0]);
        n      = size ? 2 : 1;
        exp_rd = req && !wr && (first == 0);
        exp_wr = req && wr && (first + n - 1 == 3);
        for (int k = 0; k < 4; k++) begin bus[k] = 8'h00; on_bus[k] = 1'b0; end
        h_req = req; h_wr = wr; h_addr = addr; h_size = size; h_wdata = wd;
        #1;
        check_eq(rq, "r_rd", {31'd0, r_rd}, {31'd0, exp_rd});
        check_eq(rq, "r_wr", {31'd0, r_wr}, {31'd0, exp_wr});
        if (exp_rd || exp_wr) check_eq(rq, "r_addr", {26'd0, r_addr}, {26'd0, addr[AW-1:2]});
        expr = 16'h0;
        if (req && !wr) begin
            if (exp_rd) begin
                word = mem[addr[AW-1:2]];
                for (int k = 0; k < 4; k++) rc[k] = word[31-8*k -: 8];
            end
            expr = (n == 2) ? {rc[first], rc[first+1]} : {8'h00, rc[first]};
        end
        if (req && wr) begin
            if (n == 2) begin
                bus[first] = wd[15:8]; bus[first+1] = wd[7:0];
                on_bus[first] = 1'b1; on_bus[first+1] = 1'b1;
            end else begin
                bus[first] = wd[7:0]; on_bus[first] = 1'b1;
            end
            if (exp_wr) begin
                for (int k = 0; k < 4; k++) expw[31-8*k -: 8] = on_bus[k] ? bus[k] : wc[k];
                check_eq(rq, "r_wdata", r_wdata, expw);
            end else begin
                for (int k = 0; k < 4; k++) if (on_bus[k]) wc[k] = bus[k];
            end
        end
        @(posedge clk);
        #1;
        check_eq(rq, "h_rvalid", {31'd0, h_rvalid}, {31'd0, (req && !wr)});
        if (req && !wr) check_eq(rq, "h_rdata", {16'd0, h_rdata}, {16'd0, expr});
        @(negedge clk);
    endtask

    task automatic idle(input string rq);
        op(1'b0, 1'b0, '0, 1'b0, 16'h0, rq);
    endtask

    initial begin
        #500000;
        errs++; checks++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mem[i] <= 32'hA0B1C2D3 + 32'h01010101 * i;
        for (int k = 0; k < 4; k++) begin rc[k] = 8'h00; wc[k] = 8'h00; end
        rst_n = 1'b0; h_req = 1'b0; h_wr = 1'b0; h_size = 1'b0; h_addr = '0; h_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on the host port
        check_eq("R1", "h_rvalid after reset", {31'd0, h_rvalid}, 32'd0);
        check_eq("R1", "h_rdata after reset", {16'd0, h_rdata}, 32'd0);
        // R1: caches start at zero
        op(1'b1, 1'b0, {6'd5, 2'd3}, 1'b0, 16'h0, "R1");
        op(1'b1, 1'b1, {6'd2, 2'd3}, 1'b0, 16'h005A, "R1");
        check_eq("R1", "mem after lone commit", mem[2], 32'h0000005A);
        // R3 R5: refill then partial reads, back to back
        op(1'b1, 1'b0, {6'd5, 2'd0}, 1'b1, 16'h0, "R3");
        op(1'b1, 1'b0, {6'd5, 2'd2}, 1'b1, 16'h0, "R5");
        op(1'b1, 1'b0, {6'd5, 2'd1}, 1'b0, 16'h0, "R5");
        op(1'b1, 1'b0, {6'd5, 2'd3}, 1'b0, 16'h0, "R2");
        // R4: partial read of another register served from stale cache
        op(1'b1, 1'b0, {6'd7, 2'd0}, 1'b0, 16'h0, "R3");
        op(1'b1, 1'b0, {6'd9, 2'd2}, 1'b1, 16'h0, "R4");
        // R2: halfword with address bit 0 set
        op(1'b1, 1'b0, {6'd8, 2'd1}, 1'b1, 16'h0, "R2");
        op(1'b1, 1'b0, {6'd8, 2'd3}, 1'b1, 16'h0, "R2");
        // R6 R7: build a word from pieces, LSB last
        op(1'b1, 1'b1, {6'd3, 2'd0}, 1'b1, 16'h1122, "R6");
        op(1'b1, 1'b1, {6'd3, 2'd2}, 1'b0, 16'h0033, "R6");
        op(1'b1, 1'b1, {6'd3, 2'd3}, 1'b0, 16'h0044, "R7");
        check_eq("R7", "mem[3] committed", mem[3], 32'h11223344);
        // R8: commit leaves write cache; stale bytes reach another register
        op(1'b1, 1'b1, {6'd4, 2'd3}, 1'b0, 16'h0055, "R8");
        check_eq("R8", "mem[4] stale merge", mem[4], 32'h11223355);
        op(1'b1, 1'b1, {6'd4, 2'd2}, 1'b0, 16'h0066, "R6");
        op(1'b1, 1'b1, {6'd6, 2'd2}, 1'b1, 16'h7788, "R7");
        check_eq("R7", "mem[6] bus overrides cache", mem[6], 32'h11227788);
        op(1'b1, 1'b1, {6'd6, 2'd3}, 1'b0, 16'h0099, "R8");
        check_eq("R8", "mem[6] cache kept over commit", mem[6], 32'h11226699);
        // R9: interleaved reads and writes leave each other's cache alone
        op(1'b1, 1'b0, {6'd10, 2'd0}, 1'b0, 16'h0, "R9");
        op(1'b1, 1'b1, {6'd11, 2'd0}, 1'b1, 16'hCAFE, "R9");
        op(1'b1, 1'b0, {6'd12, 2'd3}, 1'b0, 16'h0, "R9");
        op(1'b1, 1'b0, {6'd12, 2'd1}, 1'b0, 16'h0, "R9");
        op(1'b1, 1'b1, {6'd11, 2'd3}, 1'b0, 16'h00EE, "R9");
        check_eq("R9", "mem[11] after read in between", mem[11], 32'hCAFE66EE);
        // R10: idle cycles
        idle("R10");
        idle("R10");
        op(1'b1, 1'b0, {6'd11, 2'd0}, 1'b1, 16'h0, "R3");
        idle("R10");
        // R2: mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            op(rnd[0] | rnd[1], rnd[2], rnd[15:8], rnd[3], rnd[31:16], "R2");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule